// File: doc/BRIEF.md
# Device Interrupt Mapping Controller

This block holds one routing entry for each device interrupt source. Each entry stores a target CPU number, an interrupt vector, a mask bit and a pending bit. A CPU programs the entries through a simple register port that has separate read and write strobes. Reads return data one cycle after the strobe.

Device interrupt lines are level signals and are sampled on the rising clock edge. When a line is high and its entry is unmasked, the block accepts the interrupt. It sets the entry's pending bit and mask bit in the same step, and on the following cycle it raises a single-cycle post pulse that carries the entry's CPU and vector. Because acceptance re-masks the source, each source delivers at most one interrupt until software clears pending and unmasks it again.

The post output has no back-pressure. The consumer must take every pulse in the cycle it appears, and at most one post is issued per cycle. If several unmasked sources are high together, the lowest-numbered one is taken first. The others stay unmasked and are taken on later cycles for as long as their lines remain high.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every entry reads back as masked and not pending, with target CPU 0 and vector 0, and no post is issued.
- R2: A routing register stores the target CPU from write bits 12:8 and the vector from bits 5:0. A read returns the same layout, with every other bit reading as zero.
- R3: A control register read returns the mask in bit 2 and the pending flag in bit 0, with all other bits zero.
- R4: A control write loads the mask from write bit 2. A 1 in write bit 1 clears pending, and a 0 there leaves pending unchanged.
- R5: A high interrupt line on a masked entry is ignored: no post is issued and pending does not change.
- R6: When an interrupt is accepted on a clock edge, that edge sets both mask and pending. Post valid is high for the following cycle, carrying the entry's CPU and vector.
- R7: Each acceptance yields exactly one post cycle. A line that stays high after acceptance produces no further post.
- R8: When several unmasked lines are high in one cycle, the lowest index is accepted. The others are accepted one per cycle afterwards while their lines stay high.
- R9: When a control write and an acceptance hit the same entry on the same edge, the acceptance wins, leaving mask and pending both at 1.
- R10: Address bit 9 selects the bank (0 routing, 1 control), and the entry index is the byte offset shifted right by 3, so bits 2:0 are ignored. An index at or beyond the source count reads as zero, and writes to it have no effect.
- R11: Read data is registered. It reflects the state before the edge that samples the read strobe, and it holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Level interrupt line per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| post_valid | output | 1 | Single-cycle post request |
| post_cpu | output | CPU_W | Target CPU of the post |
| post_vec | output | VEC_W | Vector of the post |

## Verification
The bench targets the collision of a control write with an acceptance on one entry. A design that lets the write win would leave the source unmasked, or would clear a pending flag it has just set. It fires several sources together to expose wrong priority or lost interrupts, which would show up as a post with the wrong CPU and vector, or as a source that never posts. A line held high after acceptance catches a design that fails to re-mask, because such a design posts repeatedly. Out-of-range and low-bit addressing catch decoders that alias onto a real entry. A read issued on the same edge as an acceptance catches read data taken after the update.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // Field positions in the register data word
  localparam int CPU_LSB  = 8;
  localparam int VEC_LSB  = 0;
  localparam int MASK_BIT = 2;
  localparam int CLR_BIT  = 1;
  localparam int PEND_BIT = 0;
  // Low address bits below the 8-byte word
  localparam int WORD_SHIFT = 3;

  typedef enum logic {
    BANK_ROUTE = 1'b0,
    BANK_CTRL  = 1'b1
  } bank_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_route_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 10,
  localparam int IDX_W = ADDR_W - 1 - WORD_SHIFT
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [N_SRC-1:0]  wr_route,
  output logic [N_SRC-1:0]  wr_ctrl,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range,
  output bank_e             bank
);
  logic unused_low_addr;
  assign unused_low_addr = ^reg_addr[WORD_SHIFT-1:0];

  always_comb begin
    idx      = reg_addr[ADDR_W-2:WORD_SHIFT];
    bank     = bank_e'(reg_addr[ADDR_W-1]);
    in_range = (32'(idx) < N_SRC);
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_strobe
    always_comb begin
      wr_route[i] = reg_wr && (bank == BANK_ROUTE) && (idx == IDX_W'(i));
      wr_ctrl[i]  = reg_wr && (bank == BANK_CTRL)  && (idx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/irq_entry.sv
module irq_entry
  import irq_route_pkg::*;
#(
  parameter int CPU_W = 5,
  parameter int VEC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_line,
  input  logic             grant,
  input  logic             wr_route,
  input  logic             wr_ctrl,
  input  logic [CPU_W-1:0] wr_cpu,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic             wr_mask,
  input  logic             wr_clr,
  output logic             req,
  output logic [CPU_W-1:0] cpu,
  output logic [VEC_W-1:0] vec,
  output logic             mask,
  output logic             pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu <= '0;
      vec <= '0;
    end else if (wr_route) begin
      cpu <= wr_cpu;
      vec <= wr_vec;
    end
  end

  // Acceptance outranks a same-edge control write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= 1'b1;
      pend <= 1'b0;
    end else if (grant) begin
      mask <= 1'b1;
      pend <= 1'b1;
    end else if (wr_ctrl) begin
      mask <= wr_mask;
      if (wr_clr) pend <= 1'b0;
    end
  end

  assign req = irq_line && !mask;

  // R6
  accept_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (mask && pend));
  // R5
  grant_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !mask);
  // R5
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(grant));
  // R4
  clear_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wr_clr && !grant) |=> !pend);
  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && !wr_ctrl) |=> mask);
  // R9
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && wr_ctrl) |=> (mask && pend));
endmodule

// File: rtl/irq_post_arb.sv
module irq_post_arb #(
  parameter int N_SRC = 8,
  parameter int CPU_W = 5,
  parameter int VEC_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_SRC-1:0]             req,
  input  logic [N_SRC-1:0][CPU_W-1:0]  cpu_arr,
  input  logic [N_SRC-1:0][VEC_W-1:0]  vec_arr,
  output logic [N_SRC-1:0]             grant,
  output logic                         post_valid,
  output logic [CPU_W-1:0]             post_cpu,
  output logic [VEC_W-1:0]             post_vec
);
  logic             any_grant;
  logic [CPU_W-1:0] sel_cpu;
  logic [VEC_W-1:0] sel_vec;

  // Fixed priority, lowest index first
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    any_grant = found;
  end

  always_comb begin
    sel_cpu = '0;
    sel_vec = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (grant[i]) begin
        sel_cpu = sel_cpu | cpu_arr[i];
        sel_vec = sel_vec | vec_arr[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      post_valid <= 1'b0;
      post_cpu   <= '0;
      post_vec   <= '0;
    end else begin
      post_valid <= any_grant;
      if (any_grant) begin
        post_cpu <= sel_cpu;
        post_vec <= sel_vec;
      end
    end
  end

  // R6
  post_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |=> post_valid);
  // R7
  post_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |-> $past(|req));

  for (genvar i = 1; i < N_SRC; i++) begin : g_prio
    // R8
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> (req[i-1:0] == '0));
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int CPU_W  = 5,
  parameter int VEC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              post_valid,
  output logic [CPU_W-1:0]  post_cpu,
  output logic [VEC_W-1:0]  post_vec
);
  localparam int IDX_W = ADDR_W - 1 - WORD_SHIFT;

  logic [N_SRC-1:0]            wr_route, wr_ctrl, req, grant, mask, pend;
  logic [N_SRC-1:0][CPU_W-1:0] cpu_arr;
  logic [N_SRC-1:0][VEC_W-1:0] vec_arr;
  logic [IDX_W-1:0]            idx;
  logic                        in_range;
  bank_e                       bank;
  logic [CPU_W-1:0]            wr_cpu;
  logic [VEC_W-1:0]            wr_vec;
  logic [DATA_W-1:0]           rd_value;
  logic                        unused_wdata;

  assign wr_cpu       = reg_wdata[CPU_LSB +: CPU_W];
  assign wr_vec       = reg_wdata[VEC_LSB +: VEC_W];
  assign unused_wdata = ^reg_wdata;

  irq_reg_decode #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_dec (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wr_route (wr_route),
    .wr_ctrl  (wr_ctrl),
    .idx      (idx),
    .in_range (in_range),
    .bank     (bank)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_ent
    irq_entry #(.CPU_W(CPU_W), .VEC_W(VEC_W)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_line (irq_in[i]),
      .grant    (grant[i]),
      .wr_route (wr_route[i]),
      .wr_ctrl  (wr_ctrl[i]),
      .wr_cpu   (wr_cpu),
      .wr_vec   (wr_vec),
      .wr_mask  (reg_wdata[MASK_BIT]),
      .wr_clr   (reg_wdata[CLR_BIT]),
      .req      (req[i]),
      .cpu      (cpu_arr[i]),
      .vec      (vec_arr[i]),
      .mask     (mask[i]),
      .pend     (pend[i])
    );
  end

  irq_post_arb #(.N_SRC(N_SRC), .CPU_W(CPU_W), .VEC_W(VEC_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .cpu_arr    (cpu_arr),
    .vec_arr    (vec_arr),
    .grant      (grant),
    .post_valid (post_valid),
    .post_cpu   (post_cpu),
    .post_vec   (post_vec)
  );

  always_comb begin
    rd_value = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (in_range && idx == IDX_W'(i)) begin
        if (bank == BANK_ROUTE) begin
          rd_value[CPU_LSB +: CPU_W] = cpu_arr[i];
          rd_value[VEC_LSB +: VEC_W] = vec_arr[i];
        end else begin
          rd_value[MASK_BIT] = mask[i];
          rd_value[PEND_BIT] = pend[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_value;
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
  // R10
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !in_range) |=> (reg_rdata == '0));
  // R5
  masked_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & mask) == '0);
endmodule

// File: tb/tb_irq_route_ctrl.sv
module tb_irq_route_ctrl;
  localparam int N  = 8;
  localparam int AW = 10;
  localparam int DW = 32;

  typedef struct packed {
    logic        is_wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [7:0]  rq;
  } step_t;

  // Register table: writes, then read-back checks of the expected word
  localparam step_t TBL [15] = '{
    '{1'b1, 10'h000, 32'h0000_1F3F, 8'd2},  // R2 write src0
    '{1'b0, 10'h000, 32'h0000_1F3F, 8'd2},  // R2
    '{1'b1, 10'h008, 32'hFFFF_FFFF, 8'd2},  // R2 extra bits dropped
    '{1'b0, 10'h008, 32'h0000_1F3F, 8'd2},  // R2
    '{1'b0, 10'h00F, 32'h0000_1F3F, 8'd10}, // R10 low bits ignored
    '{1'b1, 10'h010, 32'h0000_0A15, 8'd2},  // R2
    '{1'b0, 10'h010, 32'h0000_0A15, 8'd2},  // R2
    '{1'b0, 10'h200, 32'h0000_0004, 8'd3},  // R3 masked, idle
    '{1'b1, 10'h040, 32'h0000_0505, 8'd10}, // R10 index 8 out of range
    '{1'b0, 10'h040, 32'h0000_0000, 8'd10}, // R10
    '{1'b0, 10'h000, 32'h0000_1F3F, 8'd10}, // R10 no alias to src0
    '{1'b1, 10'h218, 32'h0000_0000, 8'd4},  // R4 unmask src3
    '{1'b0, 10'h218, 32'h0000_0000, 8'd4},  // R4
    '{1'b1, 10'h218, 32'h0000_0004, 8'd4},  // R4 remask
    '{1'b0, 10'h218, 32'h0000_0004, 8'd4}   // R4
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq;
  logic          wr, rd;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          pv;
  logic [4:0]    pc;
  logic [5:0]    pvec;

  int checks = 0;
  int errs   = 0;

  always #5 clk = ~clk;

  irq_route_ctrl #(.N_SRC(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq),
    .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .post_valid(pv), .post_cpu(pc), .post_vec(pvec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_post(input string tag, input logic v, input logic [4:0] c, input logic [5:0] vv);
    check(tag, {19'd0, pv, 1'b0, pc, vv == vv ? pvec : 6'd0}, {19'd0, v, 1'b0, c, vv});
  endtask

  // Tasks start and end on a falling edge
  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    rst_n = 1'b0; irq = '0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_post("R1 post idle", 1'b0, 5'd0, 6'd0);
    for (int i = 0; i < N; i++) begin
      rd_reg(AW'(i * 8), d);
      check("R1 route", d, 32'h0);
      rd_reg(AW'(10'h200 + i * 8), d);
      check("R1 ctrl", d, 32'h4);
    end

    // Table walk
    for (int k = 0; k < 15; k++) begin
      if (TBL[k].is_wr) wr_reg(TBL[k].addr, TBL[k].data);
      else begin
        rd_reg(TBL[k].addr, d);
        check($sformatf("R%0d table step %0d", TBL[k].rq, k), d, TBL[k].data);
      end
    end

    // R5 masked source ignored
    irq[2] = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check_post("R5 no post", 1'b0, pc, pvec);
    end
    irq[2] = 1'b0;
    rd_reg(10'h210, d);
    check("R5 pend unchanged", d, 32'h4);

    // R6 accept and post, R7 single pulse with line held
    wr_reg(10'h010, 32'h0000_0521);
    wr_reg(10'h210, 32'h0);
    irq[2] = 1'b1;
    @(negedge clk);
    check_post("R6 post", 1'b1, 5'd5, 6'h21);
    @(negedge clk);
    check_post("R7 no repeat", 1'b0, pc, pvec);
    @(negedge clk);
    check_post("R7 no repeat", 1'b0, pc, pvec);
    irq[2] = 1'b0;
    rd_reg(10'h210, d);
    check("R6 mask+pend", d, 32'h5);

    // R4 clear pending and unmask
    wr_reg(10'h210, 32'h2);
    rd_reg(10'h210, d);
    check("R4 cleared", d, 32'h0);

    // R8 two sources together
    wr_reg(10'h008, 32'h0000_0101);
    wr_reg(10'h020, 32'h0000_0404);
    wr_reg(10'h208, 32'h0);
    wr_reg(10'h220, 32'h0);
    irq[1] = 1'b1; irq[4] = 1'b1;
    @(negedge clk);
    check_post("R8 first low", 1'b1, 5'd1, 6'd1);
    @(negedge clk);
    check_post("R8 second", 1'b1, 5'd4, 6'd4);
    irq = '0;
    @(negedge clk);
    check_post("R8 done", 1'b0, pc, pvec);
    rd_reg(10'h208, d);
    check("R8 src1 ctrl", d, 32'h5);
    rd_reg(10'h220, d);
    check("R8 src4 ctrl", d, 32'h5);

    // R9 write vs accept on same edge
    wr_reg(10'h030, 32'h0000_0606);
    wr_reg(10'h230, 32'h0);
    irq[6] = 1'b1; wr = 1'b1; addr = 10'h230; wdata = 32'h0;
    @(negedge clk);
    wr = 1'b0; irq[6] = 1'b0;
    check_post("R9 post", 1'b1, 5'd6, 6'd6);
    rd_reg(10'h230, d);
    check("R9 accept wins mask", d, 32'h5);
    wr_reg(10'h230, 32'h0);
    rd_reg(10'h230, d);
    check("R4 pend kept", d, 32'h1);
    irq[6] = 1'b1; wr = 1'b1; addr = 10'h230; wdata = 32'h2;
    @(negedge clk);
    wr = 1'b0; irq[6] = 1'b0;
    rd_reg(10'h230, d);
    check("R9 accept wins clear", d, 32'h5);

    // R11 read on accept edge returns prior state, then holds
    wr_reg(10'h200, 32'h0);
    rd = 1'b1; addr = 10'h200; irq[0] = 1'b1;
    @(negedge clk);
    rd = 1'b0; irq[0] = 1'b0;
    check("R11 pre-edge read", rdata, 32'h0);
    rd_reg(10'h200, d);
    check("R11 post-edge read", d, 32'h5);
    repeat (2) @(negedge clk);
    check("R11 hold", rdata, 32'h5);

    // R10 out-of-range control write
    wr_reg(10'h240, 32'h0);
    rd_reg(10'h238, d);
    check("R10 src7 untouched", d, 32'h4);

    summary();
    $finish;
  end
endmodule